// File: doc/BRIEF.md
# Mailbox Request Engine

This block runs one request transaction through a 256-bit shared mailbox that holds eight 32-bit dwords. The mailbox is reached through a simple dword master port. Dword 7 carries the message header, and its bit 31 shows which side holds the mailbox: the bit is set while the far side holds it. A pulse on `start` selects one of two commands. The first, establish, hands the far side four page-aligned queue base addresses and an event-queue interrupt vector. The second, destroy, sends only a header. When the engine finishes, it pulses `done` for one cycle and gives a two-bit result code.

A transaction runs in four phases. First the engine polls until it holds the mailbox. For establish it then checks the arguments. Next it writes the message with the header write last, because that write hands the mailbox over. It then polls dword 7 again until the mailbox comes back, and finally validates the response header. Polling is bounded: the number of read attempts is limited, and a fixed number of idle cycles separates two attempts.

Top module: `mbox_req_engine`

## Requirements
- R1: After `start`, the engine reads dword 7 (`bus_idx`=7, `bus_we`=0) until a read returns bit 31 clear. It makes at most POLL_LIMIT reads, with POLL_DELAY idle cycles between reads. If POLL_LIMIT reads all return bit 31 set, the engine ends with code 1 (timeout) and performs no write.
- R2: For establish (`cmd_destroy`=0), the engine checks the arguments once it holds the mailbox. If any of the four addresses has a nonzero bit below PAGE_SHIFT, or if `vec_idx` is 65536 or more, it ends with code 2 (invalid) and performs no write.
- R3: In an establish message, frame number i is address i shifted right by PAGE_SHIFT, taken as 52 bits, with i=0..3 for eq, cq, rq and sq. Its bits [47:0] occupy message bits [48i+47:48i]. Message bit b is bit b%32 of dword b/32.
- R4: In an establish message, bits [51:48] of frame i occupy message bits [192+4i+3:192+4i]. The vector's low 16 bits occupy message bits [223:208].
- R5: The header (dword 7) holds the type in [2:0] (1 for establish, 2 for destroy), version 0 in [5:3], direction 0 in bit 7, and `reset_fn` in bit 24. All other header bits are 0.
- R6: Establish writes dwords 0 to 7 in ascending order. Destroy writes only dword 7. Every request holds its address, direction and data until `bus_ack`.
- R7: After the header write, the engine polls dword 7 under the same bounded scheme as R1. If it exhausts the attempts, it ends with code 1 (timeout).
- R8: While the engine waits for the response, a read of 0xFFFFFFFF ends the transaction with code 0 if `reset_fn` was set. If `reset_fn` was clear, such a read counts as the far side still holding the mailbox.
- R9: A response with bit 31 clear ends with code 0 only if all of these hold: the type matches the request, the version is not above 0, bit 7 is 1, and bits [15:8] are 0. Any other response ends with code 3 (protocol).
- R10: `done` is high for exactly one cycle per transaction, and `err_code` is valid in that cycle. A `start` pulse during a transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (used only when idle) |
| cmd_destroy | input | 1 | 0 = establish, 1 = destroy |
| reset_fn | input | 1 | Value of the header's function-reset bit |
| eq_addr | input | ADDR_W | Event queue base address |
| cq_addr | input | ADDR_W | Completion queue base address |
| rq_addr | input | ADDR_W | Receive queue base address |
| sq_addr | input | ADDR_W | Send queue base address |
| vec_idx | input | VEC_W | Event queue interrupt vector |
| bus_req | output | 1 | Dword access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_idx | output | 3 | Dword index within the mailbox |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access accepted this cycle |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 invalid, 3 protocol |

## Verification
The assertions check the bus handshake on every cycle: a request holds steady until it is accepted, reads only ever target dword 7, writes rise one dword at a time, the header write is followed by no further write, and `done` never lasts two cycles. The bench scenarios are the only way to show the message layout, the bounded attempt count, the argument rejection with no writes, the reset escape value, and each of the response-rejection causes. Each of these needs a modelled far side that returns chosen values after a chosen number of busy reads.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [1:0] {
    ERR_OK       = 2'd0,
    ERR_TIMEOUT  = 2'd1,
    ERR_INVALID  = 2'd2,
    ERR_PROTOCOL = 2'd3
  } mbox_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OWN_RD,
    ST_OWN_GAP,
    ST_WRITE,
    ST_RSP_RD,
    ST_RSP_GAP,
    ST_FIN
  } mbox_state_e;

  localparam int unsigned MSG_DWORDS = 8;
  localparam logic [2:0]  HDR_IDX    = 3'd7;
  localparam logic [2:0]  TYPE_EST   = 3'd1;
  localparam logic [2:0]  TYPE_DES   = 3'd2;
  localparam logic [2:0]  MSG_VER    = 3'd0;
  localparam int unsigned FN_W       = 52;
  localparam int unsigned LOW_W      = 48;

  function automatic logic [31:0] make_hdr(logic [2:0] typ, logic [2:0] ver, logic rst_fn);
    logic [31:0] h;
    h        = '0;
    h[2:0]   = typ;
    h[5:3]   = ver;
    h[7]     = 1'b0;
    h[24]    = rst_fn;
    return h;
  endfunction

endpackage

// File: rtl/mbox_packer.sv
module mbox_packer
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned VEC_W      = 32
) (
  input  logic [3:0][ADDR_W-1:0] addrs,
  input  logic [VEC_W-1:0]       vec,
  input  logic [31:0]            hdr,
  input  logic [2:0]             idx,
  output logic                   args_ok,
  output logic [31:0]            dword
);

  localparam int unsigned IMG_W = MSG_DWORDS * 32;

  logic [IMG_W-1:0] img;
  logic [3:0]       aligned;

  for (genvar g = 0; g < 4; g++) begin : g_addr
    logic [FN_W-1:0] fn;
    assign fn                        = FN_W'(addrs[g] >> PAGE_SHIFT);
    assign aligned[g]                = (addrs[g][PAGE_SHIFT-1:0] == '0);
    assign img[LOW_W*g +: LOW_W]     = fn[LOW_W-1:0];
    assign img[192 + 4*g +: 4]       = fn[FN_W-1:LOW_W];
  end

  assign img[223:208] = vec[15:0];
  assign img[255:224] = hdr;

  assign args_ok = (&aligned) && ((vec >> 16) == '0);
  assign dword   = img[32*idx +: 32];

endmodule

// File: rtl/mbox_resp_chk.sv
module mbox_resp_chk
  import mbox_pkg::*;
(
  input  logic [31:0] rdata,
  input  logic [2:0]  exp_type,
  input  logic [2:0]  exp_ver,
  input  logic        rst_fn,
  output logic        owned,
  output logic        escape,
  output logic        accept
);

  assign owned  = ~rdata[31];
  assign escape = rst_fn && (rdata == 32'hFFFF_FFFF);
  assign accept = (rdata[2:0] == exp_type) &&
                  (rdata[5:3] <= exp_ver) &&
                  rdata[7] &&
                  (rdata[15:8] == 8'h00);

endmodule

// File: rtl/mbox_poll_ctr.sv
module mbox_poll_ctr #(
  parameter int unsigned POLL_LIMIT = 20000,
  parameter int unsigned POLL_DELAY = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  input  logic tick,
  output logic last_try,
  output logic gap_done
);

  localparam int unsigned CNT_W = $clog2(POLL_LIMIT + 1);
  localparam int unsigned DLY_W = $clog2(POLL_DELAY + 1);

  logic [CNT_W-1:0] tries_q, tries_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             tries_en, dly_en;

  always_comb begin
    tries_en = clr | miss;
    tries_d  = clr ? '0 : tries_q + 1'b1;
    dly_en   = miss | (tick && (dly_q != '0));
    dly_d    = miss ? DLY_W'(POLL_DELAY) : dly_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries_q <= '0;
      dly_q   <= '0;
    end else begin
      if (tries_en) tries_q <= tries_d;
      if (dly_en)   dly_q   <= dly_d;
    end
  end

  assign last_try = (tries_q == CNT_W'(POLL_LIMIT - 1));
  assign gap_done = (dly_q <= DLY_W'(1));

endmodule

// File: rtl/mbox_req_engine.sv
module mbox_req_engine
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned VEC_W      = 32,
  parameter int unsigned POLL_LIMIT = 20000,
  parameter int unsigned POLL_DELAY = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_destroy,
  input  logic              reset_fn,
  input  logic [ADDR_W-1:0] eq_addr,
  input  logic [ADDR_W-1:0] cq_addr,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [ADDR_W-1:0] sq_addr,
  input  logic [VEC_W-1:0]  vec_idx,
  output logic              bus_req,
  output logic              bus_we,
  output logic [2:0]        bus_idx,
  output logic [31:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [31:0]       bus_rdata,
  output logic              done,
  output logic [1:0]        err_code
);

  mbox_state_e state_q, state_d;
  mbox_err_e   err_q, err_d;
  logic [2:0]  idx_q, idx_d;
  logic        des_q, rstf_q;
  logic [3:0][ADDR_W-1:0] addr_q;
  logic [VEC_W-1:0]       vec_q;
  logic        cap_en, err_en, idx_en;

  logic        poll_clr, poll_miss, gap_tick, last_try, gap_done;
  logic        owned, escape, accept, args_ok;
  logic [2:0]  req_type;
  logic [31:0] hdr;

  assign req_type = des_q ? TYPE_DES : TYPE_EST;
  assign hdr      = make_hdr(req_type, MSG_VER, rstf_q);

  mbox_packer #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .VEC_W(VEC_W)
  ) i_packer (
    .addrs(addr_q), .vec(vec_q), .hdr(hdr), .idx(idx_q),
    .args_ok(args_ok), .dword(bus_wdata)
  );

  mbox_resp_chk i_resp (
    .rdata(bus_rdata), .exp_type(req_type), .exp_ver(MSG_VER), .rst_fn(rstf_q),
    .owned(owned), .escape(escape), .accept(accept)
  );

  mbox_poll_ctr #(
    .POLL_LIMIT(POLL_LIMIT), .POLL_DELAY(POLL_DELAY)
  ) i_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .miss(poll_miss), .tick(gap_tick),
    .last_try(last_try), .gap_done(gap_done)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    err_d     = err_q;
    idx_d     = idx_q;
    cap_en    = 1'b0;
    poll_clr  = 1'b0;
    poll_miss = 1'b0;
    gap_tick  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap_en   = 1'b1;
          poll_clr = 1'b1;
          state_d  = ST_OWN_RD;
        end
      end
      ST_OWN_RD: begin
        if (bus_ack) begin
          if (owned) begin
            if (des_q) begin
              idx_d   = HDR_IDX;
              state_d = ST_WRITE;
            end else if (args_ok) begin
              idx_d   = 3'd0;
              state_d = ST_WRITE;
            end else begin
              err_d   = ERR_INVALID;
              state_d = ST_FIN;
            end
          end else if (last_try) begin
            err_d   = ERR_TIMEOUT;
            state_d = ST_FIN;
          end else begin
            poll_miss = 1'b1;
            state_d   = ST_OWN_GAP;
          end
        end
      end
      ST_OWN_GAP: begin
        gap_tick = 1'b1;
        if (gap_done) state_d = ST_OWN_RD;
      end
      ST_WRITE: begin
        if (bus_ack) begin
          if (idx_q == HDR_IDX) begin
            poll_clr = 1'b1;
            state_d  = ST_RSP_RD;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      ST_RSP_RD: begin
        if (bus_ack) begin
          if (escape) begin
            err_d   = ERR_OK;
            state_d = ST_FIN;
          end else if (owned) begin
            err_d   = accept ? ERR_OK : ERR_PROTOCOL;
            state_d = ST_FIN;
          end else if (last_try) begin
            err_d   = ERR_TIMEOUT;
            state_d = ST_FIN;
          end else begin
            poll_miss = 1'b1;
            state_d   = ST_RSP_GAP;
          end
        end
      end
      ST_RSP_GAP: begin
        gap_tick = 1'b1;
        if (gap_done) state_d = ST_RSP_RD;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    err_en = (err_d != err_q);
    idx_en = (idx_d != idx_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= ERR_OK;
      idx_q   <= 3'd0;
      des_q   <= 1'b0;
      rstf_q  <= 1'b0;
      addr_q  <= '0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (err_en) err_q <= err_d;
      if (idx_en) idx_q <= idx_d;
      if (cap_en) begin
        des_q  <= cmd_destroy;
        rstf_q <= reset_fn;
        addr_q <= {sq_addr, rq_addr, cq_addr, eq_addr};
        vec_q  <= vec_idx;
      end
    end
  end

  // outputs
  assign bus_req  = (state_q == ST_OWN_RD) || (state_q == ST_WRITE) || (state_q == ST_RSP_RD);
  assign bus_we   = (state_q == ST_WRITE);
  assign bus_idx  = (state_q == ST_WRITE) ? idx_q : HDR_IDX;
  assign done     = (state_q == ST_FIN);
  assign err_code = err_q;

endmodule

// File: rtl/mbox_req_engine_chk.sv
module mbox_req_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_we,
  input logic [2:0]  bus_idx,
  input logic [31:0] bus_wdata,
  input logic        bus_ack,
  input logic        done
);

  // R6: an unaccepted request holds steady
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_idx) && $stable(bus_wdata));

  // R1 / R7: polling reads only look at the header dword
  assert_read_hdr_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> bus_idx == 3'd7);

  // R6: writes advance one dword at a time
  assert_write_ascending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_ack && bus_idx != 3'd7 |=> bus_req && bus_we && bus_idx == $past(bus_idx) + 3'd1);

  // R5: the header write is the last write of the message
  assert_header_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_ack && bus_idx == 3'd7 |=> !(bus_req && bus_we));

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind mbox_req_engine mbox_req_engine_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_idx(bus_idx),
  .bus_wdata(bus_wdata), .bus_ack(bus_ack), .done(done)
);

// File: tb/test_mbox_req_engine.sv
module test_mbox_req_engine;

  localparam int unsigned LIM = 6;
  localparam int unsigned DLY = 3;

  typedef struct packed {
    logic        is_done;
    logic [2:0]  idx;
    logic [31:0] data;
    logic [1:0]  err;
  } exp_t;

  logic clk, rst_n, start, cmd_destroy, reset_fn;
  logic [63:0] eq_addr, cq_addr, rq_addr, sq_addr;
  logic [31:0] vec_idx;
  logic bus_req, bus_we, bus_ack, done;
  logic [2:0] bus_idx;
  logic [31:0] bus_wdata, bus_rdata;
  logic [1:0] err_code;

  exp_t  expq[$];
  string tagq[$];
  int checks = 0, failures = 0, cycles = 0, rd_cnt = 0, done_cnt = 0;
  int busy_left = 0, rsp_busy = 0;
  logic [31:0] rd_word = '0, rsp_val = '0;
  logic stall_en = 1'b0, phase = 1'b0;

  mbox_req_engine #(.POLL_LIMIT(LIM), .POLL_DELAY(DLY)) i_mbox_req_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_destroy(cmd_destroy), .reset_fn(reset_fn),
    .eq_addr(eq_addr), .cq_addr(cq_addr), .rq_addr(rq_addr), .sq_addr(sq_addr), .vec_idx(vec_idx),
    .bus_req(bus_req), .bus_we(bus_we), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .err_code(err_code));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // far-side model
  assign bus_ack   = bus_req && !(stall_en && phase);
  assign bus_rdata = (busy_left > 0) ? 32'h8000_0000 : rd_word;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    phase  <= ~phase;
    if (bus_req && bus_ack) begin
      if (bus_we) begin
        if (bus_idx == 3'd7) begin
          busy_left <= rsp_busy;
          rd_word   <= rsp_val;
        end
      end else begin
        rd_cnt <= rd_cnt + 1;
        if (busy_left > 0) busy_left <= busy_left - 1;
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_n && bus_req && bus_ack && bus_we) begin
      if (expq.size() == 0 || expq[0].is_done) begin
        check(0, "R6 unexpected write", {29'd0, bus_idx}, 32'hFFFF_FFFF);
      end else begin
        exp_t e; string t;
        e = expq.pop_front(); t = tagq.pop_front();
        check(bus_idx == e.idx && bus_wdata == e.data, t, bus_wdata, e.data);
      end
    end
    if (rst_n && done) begin
      done_cnt++;
      if (expq.size() == 0 || !expq[0].is_done) begin
        check(0, "R10 unexpected done", {30'd0, err_code}, 32'hFFFF_FFFF);
      end else begin
        exp_t e; string t;
        e = expq.pop_front(); t = tagq.pop_front();
        check(err_code == e.err, t, {30'd0, err_code}, {30'd0, e.err});
      end
    end
  end

  function automatic logic [255:0] exp_img(logic [63:0] a0, logic [63:0] a1, logic [63:0] a2,
                                           logic [63:0] a3, logic [31:0] v, logic [31:0] h);
    logic [255:0] m;
    logic [63:0]  a [4];
    a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
    m = '0;
    for (int i = 0; i < 4; i++) begin
      logic [63:0] fn;
      fn = a[i] >> 12;
      m[48*i +: 48]     = fn[47:0];
      m[192 + 4*i +: 4] = fn[51:48];
    end
    m[223:208] = v[15:0];
    m[255:224] = h;
    return m;
  endfunction

  // driver: push expectations, then launch
  task automatic run_txn(string tag, bit des, bit rf, logic [63:0] a0, logic [63:0] a1,
                         logic [63:0] a2, logic [63:0] a3, logic [31:0] v, bit writes,
                         int pre_busy, int rbusy, logic [31:0] rval, logic [1:0] exp_err,
                         bit dbl_start, int exp_reads);
    logic [31:0]  h;
    logic [255:0] m;
    exp_t e;
    int d0;
    h = {7'd0, rf, 16'd0, 8'(des ? 3'd2 : 3'd1)};
    m = exp_img(a0, a1, a2, a3, v, h);
    if (writes) begin
      for (int i = (des ? 7 : 0); i < 8; i++) begin
        e = '{1'b0, 3'(i), m[32*i +: 32], 2'd0};
        expq.push_back(e); tagq.push_back({tag, " dword"});
      end
    end
    e = '{1'b1, 3'd0, 32'd0, exp_err};
    expq.push_back(e); tagq.push_back({tag, " code"});
    @(negedge clk);
    busy_left = pre_busy; rd_word = 32'd0; rsp_busy = rbusy; rsp_val = rval; rd_cnt = 0;
    d0 = done_cnt;
    cmd_destroy = des; reset_fn = rf; eq_addr = a0; cq_addr = a1; rq_addr = a2; sq_addr = a3;
    vec_idx = v; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (dbl_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1; cmd_destroy = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    wait (expq.size() == 0);
    repeat (12) @(negedge clk);
    check(done_cnt - d0 == 1, {tag, " R10 one done"}, done_cnt - d0, 1);
    if (exp_reads > 0) check(rd_cnt == exp_reads, {tag, " read count"}, rd_cnt, exp_reads);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  localparam logic [63:0] A0 = 64'h000F_1234_5678_9000;
  localparam logic [63:0] A1 = 64'h000A_BCDE_F012_3000;
  localparam logic [63:0] A2 = 64'h0005_5555_AAAA_B000;
  localparam logic [63:0] A3 = 64'h0000_0000_0001_0000;

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd_destroy = 1'b0; reset_fn = 1'b0;
    eq_addr = '0; cq_addr = '0; rq_addr = '0; sq_addr = '0; vec_idx = '0;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && bus_req == 1'b0, "R10 reset state", {30'd0, done, bus_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 R4 R5 R6 R9: establish with the R3/R4 layout, accepted response
    run_txn("R3 R4 establish", 0, 0, A0, A1, A2, A3, 32'h0000_BEEF, 1, 0, 0, 32'h0000_0081, 2'd0, 0, 0);
    // R1: busy reads before ownership, on a stalling bus
    stall_en = 1'b1;
    run_txn("R1 busy then owned", 0, 1, A3, A2, A1, A0, 32'h0000_FFFF, 1, 2, 1, 32'h0000_0081, 2'd0, 0, 0);
    stall_en = 1'b0;
    // R6 R5: destroy writes header only
    run_txn("R6 destroy", 1, 1, A0, A1, A2, A3, 32'd0, 1, 0, 0, 32'h0000_0082, 2'd0, 0, 0);
    // R2: misaligned address, oversize vector
    run_txn("R2 misaligned", 0, 0, A0, A1, A2 | 64'h8, A3, 32'd5, 0, 0, 0, 32'h81, 2'd2, 0, 0);
    run_txn("R2 vector", 0, 0, A0, A1, A2, A3, 32'h0001_0000, 0, 0, 0, 32'h81, 2'd2, 0, 0);
    // R1: last allowed attempt succeeds, one more exhausts
    run_txn("R1 last try", 1, 0, A0, A1, A2, A3, 32'd0, 1, LIM - 1, 0, 32'h82, 2'd0, 0, LIM + 1);
    run_txn("R1 timeout", 0, 0, A0, A1, A2, A3, 32'd0, 0, 50, 0, 32'h81, 2'd1, 0, LIM);
    // R7: response never returns
    run_txn("R7 timeout", 1, 0, A0, A1, A2, A3, 32'd0, 1, 0, 50, 32'h82, 2'd1, 0, 1 + LIM);
    // R8: reset escape value with and without reset_fn
    run_txn("R8 escape", 0, 1, A0, A1, A2, A3, 32'd9, 1, 0, 0, 32'hFFFF_FFFF, 2'd0, 0, 0);
    run_txn("R8 no escape", 1, 0, A0, A1, A2, A3, 32'd0, 1, 0, 0, 32'hFFFF_FFFF, 2'd1, 0, 1 + LIM);
    // R9: each rejection cause
    run_txn("R9 type", 0, 0, A0, A1, A2, A3, 32'd1, 1, 0, 0, 32'h0000_0082, 2'd3, 0, 0);
    run_txn("R9 version", 1, 0, A0, A1, A2, A3, 32'd0, 1, 0, 0, 32'h0000_008A, 2'd3, 0, 0);
    run_txn("R9 direction", 1, 0, A0, A1, A2, A3, 32'd0, 1, 0, 0, 32'h0000_0002, 2'd3, 0, 0);
    run_txn("R9 status", 1, 0, A0, A1, A2, A3, 32'd0, 1, 0, 1, 32'h0000_0482, 2'd3, 0, 0);
    // R10: start while busy is ignored
    run_txn("R10 busy start", 0, 0, A0, A1, A2, A3, 32'd3, 1, 3, 2, 32'h0000_0081, 2'd0, 1, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule